// File: doc/BRIEF.md
# Terminated Character String Engine

This block carries out string work directly on a plain 32-bit word-addressed memory port. It supports four operations. A move copies a string from a source address to a destination address. A compare walks two strings in step. An equal-search finds the first element that matches a given character. An unequal-search finds the first element that differs from it. An operation stops at a programmable stopper character, at the first differing element of a compare, or when a maximum element count runs out. So a zero-terminated string is handled by setting the stopper to zero, and any other terminator works the same way.

Elements are either bytes or halfwords. The walk can go up or down through memory, so that a move between overlapping buffers gives the same result as an element-by-element copy in the safe direction. Every memory access is a full 32-bit word. Reads are kept in one-word buffers. Move results collect in a write word and are written out with byte enables, so bytes outside the string stay untouched.

The host drives a one-cycle start with all operands. It then waits for a one-cycle done pulse, after which the result count, the final addresses, the compare outcome and an exhaustion flag can be read.

Top module: `strop_engine`

## Requirements
- R1: After reset, busy, done and mem_req are low. A start seen while idle makes busy high from the next cycle.
- R2: done is high for exactly one cycle, in the same cycle that busy falls. The result outputs keep their values after done until the next operation terminates.
- R3: A move (op 0) copies each element, including the terminating stopper, to the destination in walk order. A memory byte that is not a destination element keeps its value.
- R4: A compare (op 1) stops at the first index where source and destination differ, or where both hold the stopper. res_cmp is 0 for equal, 1 when the source element is unsigned-less, and 2 when it is greater. res_cmp is 0 for every other op and on exhaustion.
- R5: An equal-search (op 2) stops at the first source element equal to the stopper value. res_count gives the number of elements before it.
- R6: An unequal-search (op 3) stops at the first source element not equal to the stopper value.
- R7: When res_count would reach max_len before any terminating element is seen, the operation ends with res_exhausted=1 and res_count=max_len. max_len=0 ends at once with a count of 0.
- R8: wide=0 selects bytes, with the byte at address offset k in word bits [8k+7:8k]; only stopper[7:0] is compared. wide=1 selects halfwords at even addresses, with offset 0 in bits [15:0] and offset 2 in bits [31:16]; all 16 stopper bits are compared.
- R9: backward=1 lowers both addresses by the element size at each step, for every op. A backward move with the destination above an overlapping source, or a forward move with it below, gives the element-serial copy result.
- R10: The memory port is word addressed (byte address >> 2). Read data is taken in the cycle after the request cycle, and writes are single-cycle full words qualified by mem_be.
- R11: res_src and res_dst hold the byte addresses of the terminating element, or of the next unvisited element on exhaustion. res_count holds the number of elements before it.
- R12: A start raised while busy is ignored. The running operation finishes with its original operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (idle only) |
| op | input | 2 | 0 move, 1 compare, 2 equal-search, 3 unequal-search |
| wide | input | 1 | 1 = 16-bit elements, 0 = 8-bit |
| backward | input | 1 | 1 = walk addresses downward |
| src_addr | input | AW | Source byte address of the first element |
| dst_addr | input | AW | Destination byte address of the first element |
| stopper | input | 16 | Stopper / search character |
| max_len | input | LW | Element limit |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_count | output | LW | Elements before the terminating element |
| res_src | output | AW | Final source byte address |
| res_dst | output | AW | Final destination byte address |
| res_exhausted | output | 1 | Ended by max_len |
| res_cmp | output | 2 | Compare outcome |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | AW-2 | Word address |
| mem_be | output | 4 | Byte enables of a write |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after the request |

## Verification
busy is due one cycle after the start edge, so the bench samples it at the next falling edge. The total length of an operation depends on word crossings, so the bench waits on done instead of counting cycles. It reads every result at the falling edge where done is high, then checks one cycle later that done has dropped and that the results are unchanged. The bench compares memory against its element-serial model only after done, because the last partial write word is flushed just before done rises.

// File: rtl/strop_pkg.sv
package strop_pkg;
  typedef enum logic [1:0] {
    OP_MOVE = 2'd0,
    OP_CMP  = 2'd1,
    OP_FIND = 2'd2,
    OP_SKIP = 2'd3
  } strop_op_e;

  typedef enum logic [1:0] {
    CMP_EQ = 2'd0,
    CMP_LT = 2'd1,
    CMP_GT = 2'd2
  } strop_cmp_e;

  localparam int WORD_BYTES = 4;
endpackage

// File: rtl/strop_lane_extract.sv
module strop_lane_extract (
  input  logic [31:0] word,
  input  logic [1:0]  lane,
  input  logic        wide,
  output logic [15:0] elem
);
  always_comb begin
    if (wide) begin
      elem = lane[1] ? word[31:16] : word[15:0];
    end else begin
      case (lane)
        2'd0:    elem = {8'h00, word[7:0]};
        2'd1:    elem = {8'h00, word[15:8]};
        2'd2:    elem = {8'h00, word[23:16]};
        default: elem = {8'h00, word[31:24]};
      endcase
    end
  end
endmodule

// File: rtl/strop_lane_insert.sv
module strop_lane_insert (
  input  logic [15:0] elem,
  input  logic [1:0]  lane,
  input  logic        wide,
  output logic [31:0] data,
  output logic [3:0]  be
);
  always_comb begin
    if (wide) begin
      data = {elem, elem};
      be   = lane[1] ? 4'b1100 : 4'b0011;
    end else begin
      data = {4{elem[7:0]}};
      be   = 4'b0001 << lane;
    end
  end
endmodule

// File: rtl/strop_judge.sv
module strop_judge
  import strop_pkg::*;
(
  input  strop_op_e   op,
  input  logic        wide,
  input  logic [15:0] e_src,
  input  logic [15:0] e_dst,
  input  logic [15:0] stopper,
  output logic        hit,
  output strop_cmp_e  cres
);
  logic [15:0] stp_m;
  logic        src_is_stp;
  logic        differ;

  assign stp_m      = wide ? stopper : {8'h00, stopper[7:0]};
  assign src_is_stp = (e_src == stp_m);
  assign differ     = (e_src != e_dst);

  always_comb begin
    hit  = 1'b0;
    cres = CMP_EQ;
    case (op)
      OP_MOVE: hit = src_is_stp;
      OP_CMP: begin
        hit = differ | src_is_stp;
        if (differ) cres = (e_src < e_dst) ? CMP_LT : CMP_GT;
      end
      OP_FIND: hit = src_is_stp;
      default: hit = !src_is_stp;
    endcase
  end
endmodule

// File: rtl/strop_engine.sv
module strop_engine
  import strop_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic          wide,
  input  logic          backward,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [15:0]   stopper,
  input  logic [LW-1:0] max_len,
  output logic          busy,
  output logic          done,
  output logic [LW-1:0] res_count,
  output logic [AW-1:0] res_src,
  output logic [AW-1:0] res_dst,
  output logic          res_exhausted,
  output logic [1:0]    res_cmp,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-3:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);
  localparam int WAW = AW - 2;

  typedef enum logic [2:0] {
    S_IDLE, S_STEP, S_RSRC, S_CAPS, S_RDST, S_CAPD, S_FLUSH, S_FIN
  } state_e;

  state_e        state;
  strop_op_e     op_q;
  logic          wide_q, bwd_q, finish_q;
  logic [15:0]   stp_q;
  logic [LW-1:0] max_q, cnt;
  logic [AW-1:0] sa, da;
  logic [31:0]   sbuf, dbuf, wbuf;
  logic [WAW-1:0] sbuf_wa, dbuf_wa, wbuf_wa;
  logic          sbuf_v, dbuf_v, wbuf_v;
  logic [3:0]    wbe;

  logic [WAW-1:0] s_wa, d_wa;
  logic [15:0]   e_src, e_dst;
  logic [31:0]   ins_data, bemask;
  logic [3:0]    ins_be;
  logic          hit;
  strop_cmp_e    cres;
  logic [AW-1:0] step, nxt_sa, nxt_da;

  assign s_wa   = sa[AW-1:2];
  assign d_wa   = da[AW-1:2];
  assign step   = wide_q ? AW'(2) : AW'(1);
  assign nxt_sa = bwd_q ? sa - step : sa + step;
  assign nxt_da = bwd_q ? da - step : da + step;

  strop_lane_extract u_src_lane (.word(sbuf), .lane(sa[1:0]), .wide(wide_q), .elem(e_src));
  strop_lane_extract u_dst_lane (.word(dbuf), .lane(da[1:0]), .wide(wide_q), .elem(e_dst));
  strop_lane_insert  u_ins (.elem(e_src), .lane(da[1:0]), .wide(wide_q),
                            .data(ins_data), .be(ins_be));
  strop_judge u_judge (.op(op_q), .wide(wide_q), .e_src(e_src), .e_dst(e_dst),
                       .stopper(stp_q), .hit(hit), .cres(cres));

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_mask
    assign bemask[8*g +: 8] = {8{ins_be[g]}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      op_q <= OP_MOVE; wide_q <= 1'b0; bwd_q <= 1'b0; finish_q <= 1'b0;
      stp_q <= '0; max_q <= '0; cnt <= '0; sa <= '0; da <= '0;
      sbuf <= '0; dbuf <= '0; wbuf <= '0; wbe <= '0;
      sbuf_wa <= '0; dbuf_wa <= '0; wbuf_wa <= '0;
      sbuf_v <= 1'b0; dbuf_v <= 1'b0; wbuf_v <= 1'b0;
      busy <= 1'b0; done <= 1'b0;
      res_count <= '0; res_src <= '0; res_dst <= '0;
      res_exhausted <= 1'b0; res_cmp <= CMP_EQ;
      mem_req <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_be <= '0; mem_wdata <= '0;
    end else begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
      case (state)
        S_IDLE: begin
          done <= 1'b0;
          if (start) begin
            op_q <= strop_op_e'(op); wide_q <= wide; bwd_q <= backward;
            stp_q <= stopper; max_q <= max_len; cnt <= '0;
            sa <= src_addr; da <= dst_addr;
            sbuf_v <= 1'b0; dbuf_v <= 1'b0; wbuf_v <= 1'b0;
            busy <= 1'b1;
            state <= S_STEP;
          end
        end
        S_STEP: begin
          if (cnt == max_q) begin
            res_count <= cnt; res_src <= sa; res_dst <= da;
            res_exhausted <= 1'b1; res_cmp <= CMP_EQ;
            finish_q <= 1'b1;
            state <= wbuf_v ? S_FLUSH : S_FIN;
          end else if (!sbuf_v || sbuf_wa != s_wa) begin
            mem_req <= 1'b1; mem_addr <= s_wa;
            state <= S_RSRC;
          end else if (op_q == OP_CMP && (!dbuf_v || dbuf_wa != d_wa)) begin
            mem_req <= 1'b1; mem_addr <= d_wa;
            state <= S_RDST;
          end else if (op_q == OP_MOVE && wbuf_v && wbuf_wa != d_wa) begin
            finish_q <= 1'b0;
            state <= S_FLUSH;
          end else begin
            if (op_q == OP_MOVE) begin
              wbuf    <= ((wbuf_v ? wbuf : 32'h0) & ~bemask) | (ins_data & bemask);
              wbe     <= (wbuf_v ? wbe : 4'h0) | ins_be;
              wbuf_wa <= d_wa;
              wbuf_v  <= 1'b1;
            end
            if (hit) begin
              res_count <= cnt; res_src <= sa; res_dst <= da;
              res_exhausted <= 1'b0; res_cmp <= cres;
              finish_q <= 1'b1;
              state <= (op_q == OP_MOVE) ? S_FLUSH : S_FIN;
            end else begin
              cnt <= cnt + LW'(1);
              sa <= nxt_sa;
              da <= nxt_da;
            end
          end
        end
        S_RSRC: state <= S_CAPS;
        S_CAPS: begin
          sbuf <= mem_rdata; sbuf_wa <= s_wa; sbuf_v <= 1'b1;
          state <= S_STEP;
        end
        S_RDST: state <= S_CAPD;
        S_CAPD: begin
          dbuf <= mem_rdata; dbuf_wa <= d_wa; dbuf_v <= 1'b1;
          state <= S_STEP;
        end
        S_FLUSH: begin
          mem_req <= 1'b1; mem_we <= 1'b1;
          mem_addr <= wbuf_wa; mem_be <= wbe; mem_wdata <= wbuf;
          wbuf_v <= 1'b0;
          if (sbuf_wa == wbuf_wa) sbuf_v <= 1'b0;
          state <= finish_q ? S_FIN : S_STEP;
        end
        default: begin
          done <= 1'b1;
          busy <= 1'b0;
          state <= S_IDLE;
        end
      endcase
    end
  end

  // R2: completion pulse lasts one cycle
  a_r2_done_single: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R2: busy is already low while done is high
  a_r2_done_not_busy: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R3: only a move ever writes memory
  a_r3_write_only_move: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (op_q == OP_MOVE));
  // R10: every write carries at least one byte lane
  a_r10_write_lanes: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_be != 4'h0));
  // R7: the running count never passes the limit
  a_r7_count_bounded: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= max_q));
  // R7: exhaustion reports exactly the limit
  a_r7_exhaust_count: assert property (@(posedge clk) disable iff (rst)
    (done && res_exhausted) |-> (res_count == max_q));
  // R12: operands stay put while a start arrives during an operation
  a_r12_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(op_q) && $stable(stp_q) && $stable(max_q)));
endmodule

// File: tb/strop_engine_tb_top.sv
module strop_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int LW = 8;
  localparam int NBYTES = 1 << AW;

  logic clk = 1'b0;
  logic rst, start, wide, backward;
  logic [1:0] op;
  logic [AW-1:0] src_addr, dst_addr;
  logic [15:0] stopper;
  logic [LW-1:0] max_len;
  logic busy, done, res_exhausted, mem_req, mem_we;
  logic [LW-1:0] res_count;
  logic [AW-1:0] res_src, res_dst;
  logic [1:0] res_cmp;
  logic [AW-3:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, mem_rdata;

  logic [31:0] mem [0:NBYTES/4-1];
  logic [7:0]  rb  [0:NBYTES-1];

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strop_engine #(.AW(AW), .LW(LW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .op(op), .wide(wide), .backward(backward),
    .src_addr(src_addr), .dst_addr(dst_addr), .stopper(stopper), .max_len(max_len),
    .busy(busy), .done(done), .res_count(res_count), .res_src(res_src), .res_dst(res_dst),
    .res_exhausted(res_exhausted), .res_cmp(res_cmp), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= mem[mem_addr];
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_el(input int a, input bit w, input int v);
    rb[a] = v[7:0];
    mem[a >> 2][8*(a & 3) +: 8] = v[7:0];
    if (w) begin
      rb[a+1] = v[15:8];
      mem[(a+1) >> 2][8*((a+1) & 3) +: 8] = v[15:8];
    end
  endtask

  function automatic int get_el(input int a, input bit w);
    return w ? {16'h0, rb[a+1], rb[a]} : {24'h0, rb[a]};
  endfunction

  task automatic fill(input int seed);
    for (int i = 0; i < NBYTES; i++) begin
      logic [7:0] b;
      b = 8'((i * 29 + seed * 11 + 7) & 255);
      if (b == 8'h5A) b = 8'h5B;
      rb[i] = b;
      mem[i >> 2][8*(i & 3) +: 8] = b;
    end
  endtask

  // Element-serial reference; updates rb for a move
  task automatic model(input int mop, input bit w, input bit bk, input int sa0, input int da0,
                       input int stp, input int maxl, output int cnt, output int exh,
                       output int cmpv, output int rs, output int rd);
    int st, a, d, es, ed, fin;
    st = w ? 2 : 1;
    a = sa0; d = da0; cnt = 0; exh = 0; cmpv = 0; fin = 0;
    while (!fin) begin
      if (cnt == maxl) begin
        exh = 1; fin = 1;
      end else begin
        es = get_el(a, w);
        case (mop)
          0: begin
            rb[d] = es[7:0];
            if (w) rb[d+1] = es[15:8];
            fin = (es == stp);
          end
          1: begin
            ed = get_el(d, w);
            if (es != ed) begin
              cmpv = (es < ed) ? 1 : 2; fin = 1;
            end else fin = (es == stp);
          end
          2: fin = (es == stp);
          default: fin = (es != stp);
        endcase
        if (!fin) begin
          cnt++;
          a = bk ? a - st : a + st;
          d = bk ? d - st : d + st;
        end
      end
    end
    rs = a; rd = d;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int t = 0; t < 600; t++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic run_case(input int mop, input bit w, input bit bk, input int sa0,
                          input int da0, input int maxl, input string tag);
    int ecnt, eexh, ecmp, ers, erd, stpm, bad;
    bit ok;
    logic [15:0] stin;
    stin = w ? 16'h5A5A : 16'hC35A;
    stpm = w ? 32'h5A5A : 32'h5A;
    model(mop, w, bk, sa0, da0, stpm, maxl, ecnt, eexh, ecmp, ers, erd);
    @(negedge clk);
    op = 2'(mop); wide = w; backward = bk; src_addr = AW'(sa0); dst_addr = AW'(da0);
    stopper = stin; max_len = LW'(maxl); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R1 busy after start", 32'(busy), 32'd1);
    wait_done(ok);
    check("R2 done arrives", 32'(ok), 32'd1);
    check({tag, " R11 count"}, 32'(res_count), 32'(ecnt));
    check("R7 exhausted flag", 32'(res_exhausted), 32'(eexh));
    check("R4 compare outcome", 32'(res_cmp), 32'(ecmp));
    check("R11 R9 source address", 32'(res_src), 32'(ers));
    check("R11 R9 destination address", 32'(res_dst), 32'(erd));
    bad = 0;
    for (int i = 0; i < NBYTES; i++)
      if (mem[i >> 2][8*(i & 3) +: 8] !== rb[i]) bad++;
    check({tag, " R3 R10 memory image mismatched bytes"}, 32'(bad), 32'd0);
    @(negedge clk);
    check("R2 done single cycle", 32'(done), 32'd0);
    check("R2 count held", 32'(res_count), 32'(ecnt));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    int seed;
    int lens [4];
    lens = '{0, 1, 3, 6};
    seed = 0;
    rst = 1'b1; start = 1'b0; op = 2'd0; wide = 1'b0; backward = 1'b0;
    src_addr = '0; dst_addr = '0; stopper = '0; max_len = '0;
    for (int i = 0; i < NBYTES/4; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset busy", 32'(busy), 32'd0);
    check("R1 reset done", 32'(done), 32'd0);
    check("R1 reset mem_req", 32'(mem_req), 32'd0);

    for (int w = 0; w < 2; w++)
      for (int bk = 0; bk < 2; bk++)
        for (int mop = 0; mop < 4; mop++)
          for (int al = 0; al < 4; al++)
            for (int li = 0; li < 4; li++)
              for (int v = 0; v < 2; v++)
                for (int mlv = 0; mlv < 2; mlv++) begin
                  int st, sa0, da0, L, stpm, maxl;
                  string tag;
                  if (w == 1 && (al % 2) == 1) continue;
                  seed++;
                  fill(seed);
                  st = w ? 2 : 1;
                  L = lens[li];
                  stpm = w ? 32'h5A5A : 32'h5A;
                  sa0 = bk ? 296 + al : 256 + al;
                  if (mop == 0 && v == 1) da0 = bk ? sa0 + (w ? 2 : 3) : sa0 - (w ? 2 : 3);
                  else da0 = sa0 + 300 + ((al * 3) & (w ? 2 : 3));
                  if (mop == 3) begin
                    for (int k = 0; k < L; k++) put_el(bk ? sa0 - k*st : sa0 + k*st, w[0], stpm);
                  end else begin
                    put_el(bk ? sa0 - L*st : sa0 + L*st, w[0], stpm);
                  end
                  if (mop == 1) begin
                    for (int k = 0; k <= L; k++) begin
                      int sadr, dadr;
                      sadr = bk ? sa0 - k*st : sa0 + k*st;
                      dadr = bk ? da0 - k*st : da0 + k*st;
                      put_el(dadr, w[0], get_el(sadr, w[0]));
                    end
                    if (v == 1) put_el(bk ? da0 - L*st : da0 + L*st, w[0], bk ? stpm - 1 : stpm + 1);
                  end
                  maxl = mlv ? L : L + 3;
                  case (mop)
                    0: tag = "R3 R8 R9 move";
                    1: tag = "R4 R8 compare";
                    2: tag = "R5 R8 find";
                    default: tag = "R6 R8 skip";
                  endcase
                  run_case(mop, w[0], bk[0], sa0, da0, maxl, tag);
                end

    // R12: second start during an equal-search must not disturb it
    begin
      int ecnt, eexh, ecmp, ers, erd, bad;
      bit ok;
      fill(777);
      put_el(260, 1'b0, 32'h5A);
      model(2, 1'b0, 1'b0, 256, 600, 32'h5A, 20, ecnt, eexh, ecmp, ers, erd);
      @(negedge clk);
      op = 2'd2; wide = 1'b0; backward = 1'b0; src_addr = AW'(256); dst_addr = AW'(600);
      stopper = 16'h005A; max_len = LW'(20); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      op = 2'd0; src_addr = AW'(100); dst_addr = AW'(400); stopper = 16'h0011;
      max_len = LW'(2); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(ok);
      check("R12 done arrives", 32'(ok), 32'd1);
      check("R12 original count kept", 32'(res_count), 32'(ecnt));
      check("R12 original source address kept", 32'(res_src), 32'(ers));
      bad = 0;
      for (int i = 0; i < NBYTES; i++)
        if (mem[i >> 2][8*(i & 3) +: 8] !== rb[i]) bad++;
      check("R12 no write from ignored move", 32'(bad), 32'd0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule